// File: doc/BRIEF.md
# Flash Operation Status Read Responder

This block stands in for the device side of a parallel NOR flash while an embedded program or erase is under way. A command port starts an operation (program one byte, erase a chosen set of sectors, or erase the whole chip). A small cycle counter stands in for the embedded algorithm. While that counter runs, every read returns a status byte instead of array contents. The status byte carries a data-polling bit, two toggle bits that change from one read to the next, a time-limit-exceeded flag and an erase-timer flag. A ready/busy pin tells the host when the part is working. The flash array, the bus command decoder and the analog timing all sit outside the block. Array contents arrive on `arr_rdata` for the address being read.

Operations start through a valid/ready handshake. `cmd_ready` is high only when no operation is running or suspended. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. A host that holds `cmd_valid` while `cmd_ready` is low simply waits. Nothing is lost, and the command fields must stay stable until the transfer. The read port has no back-pressure. Each `rd_en` pulse yields exactly one `rd_valid` pulse with its byte one cycle later. Suspend, resume and abort are plain single-cycle control pulses.

All durations are parameters counted in clock cycles: program time, the protected-program and protected-erase early-return windows, the sector-erase time-out, erase time, and the program time limit.

Top module: `flash_status_responder`

## Requirements
- R1: After reset, `rdy_busy` is 1 and `cmd_ready` is 1. A read returns `arr_rdata` of the addressed location on `rd_data`, with `rd_valid` high one cycle after `rd_en`.
- R2: A command is accepted only on an edge with `cmd_valid` and `cmd_ready` both high. From the next cycle, `rdy_busy` and `cmd_ready` are 0 while the operation runs. Command kind encoding: 01 program, 10 sector erase, 11 chip erase, 00 no-op.
- R3: During a program, every read at any address returns the inverse of bit 7 of the programmed byte in bit 7. Bits 4, 1 and 0 read 0 in every status byte. The program lasts `PROG_CYC` cycles; after that, reads return array data and `rdy_busy` is 1.
- R4: Bit 6 inverts on every read, at any address, while a program or erase is active, including the time-out and protected windows. It holds its value while erase is suspended.
- R5: During an erase, bit 7 reads 0. For a sector erase, bit 3 reads 0 for the first `ERASE_WAIT_CYC` cycles and 1 afterwards. A chip erase reads bit 3 as 1 from its first cycle. The erase ends after `ERASE_CYC` cycles of active erasing.
- R6: Bit 2 inverts on each read whose sector (the top `SECT_W` address bits) is in the erase set. Reads from other sectors during an erase show bit 2 as 0.
- R7: A program aimed at a sector whose `prot_mask` bit is set toggles bit 6 for `PROG_PROT_CYC` cycles, then returns to array reads with `rdy_busy` 1.
- R8: The erase set is the selected (or, for chip erase, all) sectors minus the protected ones. If that set is empty, bit 6 toggles for `ERASE_PROT_CYC` cycles and the block returns to array reads. Protected sectors in a partial set show bit 2 as 0.
- R9: A program that asks a bit to go from 0 (per `cmd_cur`) to 1 never completes. After `LIMIT_CYC` cycles, bit 5 reads 1, bit 6 keeps toggling, and `rdy_busy` stays 0 until abort.
- R10: A suspend pulse is honoured only during active erasing (after the time-out). While suspended, `rdy_busy` is 1. Reads in erase-set sectors return bit 7 = 1, a frozen bit 6 and a toggling bit 2. Reads elsewhere return array data. A suspend at any other time has no effect.
- R11: A resume pulse while suspended returns to erasing, and the erase finishes after the cycles that remained when it was suspended.
- R12: An abort pulse returns any operation to idle on the next edge: `rdy_busy` goes to 1 and reads return array data.
- R13: A read strobed on the same edge as a state change (suspend, completion) reports, and toggles according to, the state before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_kind | input | 2 | 01 program, 10 sector erase, 11 chip erase, 00 no-op |
| cmd_sect | input | SECT_W | Target sector of a program |
| cmd_data | input | 8 | Byte to program |
| cmd_cur | input | 8 | Current array byte at the program address |
| cmd_sel | input | 2**SECT_W | Sector-erase selection mask |
| prot_mask | input | 2**SECT_W | Protected-sector mask |
| susp_req | input | 1 | Erase-suspend pulse |
| resume_req | input | 1 | Erase-resume pulse |
| abort_req | input | 1 | Return-to-read pulse |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| arr_rdata | input | 8 | Array data for rd_addr, same cycle |
| rd_valid | output | 1 | Read byte available |
| rd_data | output | 8 | Array data or status byte |
| rdy_busy | output | 1 | 1 ready, 0 busy |

## Verification
A read strobe and an erase-suspend pulse can land on the same clock edge. The bench provokes this by raising `rd_en` and `susp_req` in one cycle once erasing is under way. That read must still show the running-erase status (bit 7 = 0, bit 3 = 1), and bit 6 must invert against the read before it. The reads that follow must show the suspended status with bit 6 frozen at the value left by that colliding read. A second collision is an abort pulse arriving while a timed-out program keeps bit 6 moving; the bench checks that the very next read already returns array data.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_PROG_PROT,
    ST_PROG_FAIL,
    ST_ER_WAIT,
    ST_ER_RUN,
    ST_ER_PROT,
    ST_ER_SUSP
  } op_state_t;

  localparam logic [1:0] K_NONE = 2'b00;
  localparam logic [1:0] K_PROG = 2'b01;
  localparam logic [1:0] K_SECT = 2'b10;
  localparam logic [1:0] K_CHIP = 2'b11;
endpackage

// File: rtl/op_sequencer.sv
module op_sequencer
  import flash_stat_pkg::*;
#(
  parameter int SECT_W         = 2,
  parameter int PROG_CYC       = 1000,
  parameter int PROG_PROT_CYC  = 125,
  parameter int ERASE_WAIT_CYC = 6250,
  parameter int ERASE_CYC      = 50000,
  parameter int ERASE_PROT_CYC = 12500,
  parameter int LIMIT_CYC      = 200000,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  logic [1:0]        cmd_kind,
  input  logic [SECT_W-1:0] cmd_sect,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic [BYTE_W-1:0] cmd_cur,
  input  logic [NSECT-1:0]  cmd_sel,
  input  logic [NSECT-1:0]  prot_mask,
  input  logic              susp_req,
  input  logic              resume_req,
  input  logic              abort_req,
  output op_state_t         state,
  output logic              wbit7,
  output logic [NSECT-1:0]  erase_set
);
  localparam int M1 = (PROG_CYC > PROG_PROT_CYC) ? PROG_CYC : PROG_PROT_CYC;
  localparam int M2 = (ERASE_WAIT_CYC > ERASE_CYC) ? ERASE_WAIT_CYC : ERASE_CYC;
  localparam int M3 = (ERASE_PROT_CYC > LIMIT_CYC) ? ERASE_PROT_CYC : LIMIT_CYC;
  localparam int M12 = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M12 > M3) ? M12 : M3;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt;
  logic             bad_q;
  logic [NSECT-1:0] sect_set;

  assign sect_set = cmd_sel & ~prot_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bad_q     <= 1'b0;
      wbit7     <= 1'b0;
      erase_set <= '0;
    end else if (state != ST_IDLE && abort_req) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      erase_set <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (cmd_fire) begin
            case (cmd_kind)
              K_PROG: begin
                wbit7 <= cmd_data[BYTE_W-1];
                bad_q <= |(cmd_data & ~cmd_cur);
                state <= prot_mask[cmd_sect] ? ST_PROG_PROT : ST_PROG;
              end
              K_SECT: begin
                erase_set <= sect_set;
                state     <= (sect_set == '0) ? ST_ER_PROT : ST_ER_WAIT;
              end
              K_CHIP: begin
                erase_set <= ~prot_mask;
                state     <= (~prot_mask == '0) ? ST_ER_PROT : ST_ER_RUN;
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
        ST_PROG: begin
          if (!bad_q && cnt == CNT_W'(PROG_CYC - 1)) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else if (cnt == CNT_W'(LIMIT_CYC - 1)) begin
            state <= ST_PROG_FAIL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PROG_PROT: begin
          if (cnt == CNT_W'(PROG_PROT_CYC - 1)) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PROG_FAIL: state <= ST_PROG_FAIL;
        ST_ER_WAIT: begin
          if (cnt == CNT_W'(ERASE_WAIT_CYC - 1)) begin
            state <= ST_ER_RUN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ER_RUN: begin
          if (susp_req) begin
            state <= ST_ER_SUSP;
          end else if (cnt == CNT_W'(ERASE_CYC - 1)) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            erase_set <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ER_PROT: begin
          if (cnt == CNT_W'(ERASE_PROT_CYC - 1)) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ER_SUSP: if (resume_req) state <= ST_ER_RUN;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_fail_needs_bad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG_FAIL) |-> bad_q);

  assert_susp_only_running_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_ER_RUN && state != ST_ER_SUSP) |=> (state != ST_ER_SUSP));

  assert_erase_set_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ER_WAIT || state == ST_ER_RUN || state == ST_ER_SUSP) |-> (erase_set != '0));

  assert_susp_holds_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ER_SUSP && !abort_req) |=> $stable(cnt));

  assert_abort_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> (state == ST_IDLE));
endmodule

// File: rtl/toggle_pair.sv
module toggle_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_fire,
  input  logic t1_en,
  input  logic t2_en,
  output logic t1,
  output logic t2
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t1 <= 1'b0;
      t2 <= 1'b0;
    end else begin
      if (rd_fire && t1_en) t1 <= ~t1;
      if (rd_fire && t2_en) t2 <= ~t2;
    end
  end

  assert_t1_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_fire && t1_en) |=> $stable(t1));

  assert_t2_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_fire && t2_en) |=> $stable(t2));
endmodule

// File: rtl/status_composer.sv
module status_composer
  import flash_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  op_state_t         state,
  input  logic              wbit7,
  input  logic              in_set,
  input  logic              t1,
  input  logic              t2,
  input  logic [BYTE_W-1:0] arr_rdata,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] byte_d;
  logic              b2;

  assign b2 = in_set & t2;

  always_comb begin
    case (state)
      ST_IDLE:      byte_d = arr_rdata;
      ST_PROG,
      ST_PROG_PROT: byte_d = {~wbit7, t1, 1'b0, 5'b00000};
      ST_PROG_FAIL: byte_d = {~wbit7, t1, 1'b1, 5'b00000};
      ST_ER_WAIT:   byte_d = {1'b0, t1, 1'b0, 1'b0, 1'b0, b2, 2'b00};
      ST_ER_RUN:    byte_d = {1'b0, t1, 1'b0, 1'b0, 1'b1, b2, 2'b00};
      ST_ER_PROT:   byte_d = {1'b0, t1, 6'b000000};
      ST_ER_SUSP:   byte_d = in_set ? {1'b1, t1, 1'b0, 1'b0, 1'b0, t2, 2'b00} : arr_rdata;
      default:      byte_d = arr_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= byte_d;
    end
  end

  assert_valid_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));
endmodule

// File: rtl/flash_status_responder.sv
module flash_status_responder
  import flash_stat_pkg::*;
#(
  parameter int ADDR_W         = 8,
  parameter int SECT_W         = 2,
  parameter int PROG_CYC       = 1000,
  parameter int PROG_PROT_CYC  = 125,
  parameter int ERASE_WAIT_CYC = 6250,
  parameter int ERASE_CYC      = 50000,
  parameter int ERASE_PROT_CYC = 12500,
  parameter int LIMIT_CYC      = 200000,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_kind,
  input  logic [SECT_W-1:0] cmd_sect,
  input  logic [7:0]        cmd_data,
  input  logic [7:0]        cmd_cur,
  input  logic [NSECT-1:0]  cmd_sel,
  input  logic [NSECT-1:0]  prot_mask,
  input  logic              susp_req,
  input  logic              resume_req,
  input  logic              abort_req,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        arr_rdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              rdy_busy
);
  op_state_t        state;
  logic             wbit7;
  logic [NSECT-1:0] erase_set;
  logic [SECT_W-1:0] rd_sect;
  logic             in_set, t1, t2, t1_en, t2_en, erasing;
  logic             unused_low_addr;

  assign rd_sect         = rd_addr[ADDR_W-1 -: SECT_W];
  assign unused_low_addr = ^rd_addr[ADDR_W-SECT_W-1:0];
  assign in_set          = erase_set[rd_sect];
  assign cmd_ready       = (state == ST_IDLE);
  assign rdy_busy        = (state == ST_IDLE) || (state == ST_ER_SUSP);
  assign erasing         = (state == ST_ER_WAIT) || (state == ST_ER_RUN);
  assign t1_en           = !rdy_busy;
  assign t2_en           = in_set && (erasing || state == ST_ER_SUSP);

  op_sequencer #(
    .SECT_W(SECT_W), .PROG_CYC(PROG_CYC), .PROG_PROT_CYC(PROG_PROT_CYC),
    .ERASE_WAIT_CYC(ERASE_WAIT_CYC), .ERASE_CYC(ERASE_CYC),
    .ERASE_PROT_CYC(ERASE_PROT_CYC), .LIMIT_CYC(LIMIT_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_valid && cmd_ready),
    .cmd_kind(cmd_kind), .cmd_sect(cmd_sect), .cmd_data(cmd_data),
    .cmd_cur(cmd_cur), .cmd_sel(cmd_sel), .prot_mask(prot_mask),
    .susp_req(susp_req), .resume_req(resume_req), .abort_req(abort_req),
    .state(state), .wbit7(wbit7), .erase_set(erase_set)
  );

  toggle_pair u_tog (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_en),
    .t1_en(t1_en), .t2_en(t2_en), .t1(t1), .t2(t2)
  );

  status_composer u_comp (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .state(state), .wbit7(wbit7),
    .in_set(in_set), .t1(t1), .t2(t2), .arr_rdata(arr_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assert_busy_blocks_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_busy |-> !cmd_ready);

  assert_accept_goes_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_kind != K_NONE && !abort_req) |=> !rdy_busy);
endmodule

// File: tb/test_flash_status_responder.sv
`timescale 1ns/1ps
module test_flash_status_responder;
  localparam int PC = 12, PP = 6, EW = 8, EC = 30, EP = 20, LC = 40;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, susp_req = 0, resume_req = 0, abort_req = 0, rd_en = 0;
  logic [1:0] cmd_kind = 0;
  logic [1:0] cmd_sect = 0;
  logic [7:0] cmd_data = 0, cmd_cur = 0, rd_addr = 0, arr_rdata;
  logic [3:0] cmd_sel = 0, prot_mask = 0;
  logic cmd_ready, rd_valid, rdy_busy;
  logic [7:0] rd_data;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign arr_rdata = rd_addr ^ 8'hA5;

  flash_status_responder #(.PROG_CYC(PC), .PROG_PROT_CYC(PP), .ERASE_WAIT_CYC(EW),
    .ERASE_CYC(EC), .ERASE_PROT_CYC(EP), .LIMIT_CYC(LC)) i_flash_status_responder (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_sect(cmd_sect), .cmd_data(cmd_data), .cmd_cur(cmd_cur),
    .cmd_sel(cmd_sel), .prot_mask(prot_mask), .susp_req(susp_req),
    .resume_req(resume_req), .abort_req(abort_req), .rd_en(rd_en), .rd_addr(rd_addr),
    .arr_rdata(arr_rdata), .rd_valid(rd_valid), .rd_data(rd_data), .rdy_busy(rdy_busy));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    check(rd_valid, "R1 rd_valid", rd_valid, 1);
    d = rd_data;
  endtask

  task automatic issue(input logic [1:0] k, input logic [1:0] s, input logic [7:0] dt,
                       input logic [7:0] cur, input logic [3:0] sel);
    cmd_valid = 1; cmd_kind = k; cmd_sect = s; cmd_data = dt; cmd_cur = cur; cmd_sel = sel;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_ready(input int lim, output int n);
    n = 0;
    while (!rdy_busy && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check(rdy_busy && cmd_ready, "R1 reset ready", {rdy_busy, cmd_ready}, 3);
    rd(8'h13, d);
    check(d == (8'h13 ^ 8'hA5), "R1 array read", d, 8'h13 ^ 8'hA5);
  endtask

  task automatic t_program();
    logic [7:0] a, b; int n;
    issue(2'b01, 2'd0, 8'h35, 8'hFF, 4'h0);
    check(!rdy_busy && !cmd_ready, "R2 busy after accept", {rdy_busy, cmd_ready}, 0);
    rd(8'h02, a); rd(8'hC7, b);
    check(a[7] == 1'b1 && a[5] == 0 && a[4] == 0 && a[1:0] == 0, "R3 poll bit", a, 8'h80);
    check(a[6] != b[6], "R4 bit6 toggles", b[6], !a[6]);
    wait_ready(100, n);
    check(n + 2 == PC - 1 || n + 2 == PC, "R3 program duration", n + 2, PC);
    rd(8'h02, a);
    check(a == (8'h02 ^ 8'hA5), "R3 array after program", a, 8'h02 ^ 8'hA5);
  endtask

  task automatic t_prog_timing();
    issue(2'b01, 2'd1, 8'h00, 8'hFF, 4'h0);
    repeat (PC - 2) @(negedge clk);
    check(!rdy_busy, "R3 still busy", rdy_busy, 0);
    repeat (3) @(negedge clk);
    check(rdy_busy, "R3 done", rdy_busy, 1);
  endtask

  task automatic t_sector_erase();
    logic [7:0] a, b, c; int n;
    issue(2'b10, 2'd0, 8'h00, 8'h00, 4'b0101);
    rd(8'h10, a); rd(8'h11, b); rd(8'h40, c);
    check(a[7] == 0 && a[3] == 0, "R5 erase wait status", a, 8'h00);
    check(a[2] != b[2], "R6 bit2 toggles in set", b[2], !a[2]);
    check(c[2] == 0, "R6 bit2 zero outside set", c[2], 0);
    repeat (EW) @(negedge clk);
    rd(8'h80, a);
    check(a[3] == 1 && a[7] == 0, "R5 bit3 after wait", a[3], 1);
    wait_ready(200, n);
    check(rdy_busy, "R5 erase completes", rdy_busy, 1);
  endtask

  task automatic t_chip_erase();
    logic [7:0] a; int n;
    issue(2'b11, 2'd0, 8'h00, 8'h00, 4'h0);
    rd(8'h00, a);
    check(a[3] == 1 && a[7] == 0, "R5 chip bit3 immediate", a, 8'h08);
    wait_ready(200, n);
    check(n + 1 >= EC - 2 && n + 1 <= EC + 1, "R5 chip erase duration", n + 1, EC);
  endtask

  task automatic t_prot_prog();
    logic [7:0] a, b;
    prot_mask = 4'b0010;
    issue(2'b01, 2'd1, 8'h00, 8'hFF, 4'h0);
    rd(8'h40, a); rd(8'h40, b);
    check(a[6] != b[6], "R7 protected program toggles", b[6], !a[6]);
    repeat (PP - 4) @(negedge clk);
    check(!rdy_busy, "R7 window busy", rdy_busy, 0);
    repeat (3) @(negedge clk);
    check(rdy_busy, "R7 early return", rdy_busy, 1);
    rd(8'h41, a);
    check(a == (8'h41 ^ 8'hA5), "R7 array after window", a, 8'h41 ^ 8'hA5);
  endtask

  task automatic t_prot_erase();
    logic [7:0] a, b; int n;
    issue(2'b10, 2'd0, 8'h00, 8'h00, 4'b0010);
    rd(8'h40, a); rd(8'h40, b);
    check(a[6] != b[6] && a[2] == 0, "R8 all-protected toggles", b, a);
    wait_ready(100, n);
    check(n + 2 >= EP - 2 && n + 2 <= EP + 1, "R8 protected erase window", n + 2, EP);
    issue(2'b10, 2'd0, 8'h00, 8'h00, 4'b0011);
    rd(8'h40, a); rd(8'h40, b);
    check(a[2] == 0 && b[2] == 0, "R8 protected sector bit2", {a[2], b[2]}, 0);
    rd(8'h00, a); rd(8'h00, b);
    check(a[2] != b[2], "R8 unprotected sector erasing", b[2], !a[2]);
    abort_req = 1; @(negedge clk); abort_req = 0;
    prot_mask = 4'b0000;
  endtask

  task automatic t_timeout();
    logic [7:0] a, b;
    issue(2'b01, 2'd2, 8'h0F, 8'hF0, 4'h0);
    repeat (LC + 5) @(negedge clk);
    check(!rdy_busy, "R9 stays busy", rdy_busy, 0);
    rd(8'h80, a); rd(8'h80, b);
    check(a[5] == 1 && a[7] == 1, "R9 limit flag", a, 8'hA0);
    check(a[6] != b[6], "R9 bit6 keeps toggling", b[6], !a[6]);
    abort_req = 1; @(negedge clk); abort_req = 0;
    check(rdy_busy && cmd_ready, "R12 abort to idle", rdy_busy, 1);
    rd(8'h81, a);
    check(a == (8'h81 ^ 8'hA5), "R12 array after abort", a, 8'h81 ^ 8'hA5);
  endtask

  task automatic t_suspend_resume();
    logic [7:0] a, b, c, d; int n;
    issue(2'b10, 2'd0, 8'h00, 8'h00, 4'b0001);
    susp_req = 1; @(negedge clk); susp_req = 0;
    check(!rdy_busy, "R10 suspend ignored in wait", rdy_busy, 0);
    repeat (EW) @(negedge clk);
    rd(8'h05, a);
    rd_en = 1; rd_addr = 8'h05; susp_req = 1;
    @(negedge clk);
    rd_en = 0; susp_req = 0; b = rd_data;
    check(b[7] == 0 && b[3] == 1, "R13 colliding read sees erasing", b, 8'h08);
    check(b[6] != a[6], "R13 colliding read toggles", b[6], !a[6]);
    check(rdy_busy, "R10 suspended ready", rdy_busy, 1);
    rd(8'h06, c); rd(8'h07, d);
    check(c[7] == 1 && c[6] == a[6] && d[6] == a[6], "R10 frozen bit6", c, a);
    check(c[2] != d[2], "R10 bit2 toggles suspended", d[2], !c[2]);
    rd(8'hC3, c);
    check(c == (8'hC3 ^ 8'hA5), "R10 array outside set", c, 8'hC3 ^ 8'hA5);
    repeat (10) @(negedge clk);
    resume_req = 1; @(negedge clk); resume_req = 0;
    check(!rdy_busy, "R11 resumed busy", rdy_busy, 0);
    wait_ready(200, n);
    check(n + 1 >= EC - 5 && n + 1 <= EC - 1, "R11 remaining erase", n + 1, EC - 3);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_program();
    t_prog_timing();
    t_sector_erase();
    t_chip_erase();
    t_prot_prog();
    t_prot_erase();
    t_timeout();
    t_suspend_resume();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule